// File: doc/BRIEF.md
# DRAM Rank Select and Termination Decoder

This block sits between the request path of a four-rank DRAM controller and its command sequencer. For every memory command it accepts, it works out which rank the 32-bit system address falls into and drives that rank's active-low chip select. It also drives the on-die-termination lines for all ranks according to the targeted rank's read or write termination policy. Finally, it reports whether the command should carry an auto-precharge and on which column-address bit. An address that no enabled rank claims raises a miss flag and selects nothing.

Each rank owns an 8-bit lower bound and an 8-bit upper bound, compared against the top byte of the address, plus an enable bit. Ranks 0 and 1 can be paired for interleaving. In that mode only rank 0's window, enable and precharge setting decide the hit, and one address bit picks which of the two ranks is driven. Configuration is plain level inputs. Commands enter through a valid/ready handshake, and each result leaves through a single registered valid/ready stage. A command is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high whenever the output stage is empty or its result is being consumed in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new command is taken.

Top module: `dram_cs_decode`

## Requirements
- R1: A rank hits when the address top byte `addr[31:24]` satisfies lo <= byte <= hi for that rank, both limits inclusive; a rank whose hi is below its lo never hits.
- R2: A rank whose enable bit is clear never hits, whatever its window.
- R3: When several ranks hit, the lowest-numbered one is selected, and at most one chip select is low. With no hit, `miss` is 1, all chip selects are high, all ODT lines are 0 and `ap_req` is 0.
- R4: With `cfg_pair_il` set, rank 1's own window and enable are ignored. Rank 0's window and enable decide the hit, and address bit 6 selects rank 1 (1) or rank 0 (0).
- R5: The targeted rank's 3-bit policy (read policy for reads, write policy for writes) sets the ODT lines as follows. 0 means none. 1 means only the target. 2 means every rank but the target. 3 means the ranks on the other module. 4 means all ranks. Codes 5, 6 and 7 drive none.
- R6: Ranks 0 and 1 form one module and ranks 2 and 3 the other. For code 3, a target in ranks 0 or 1 drives ODT on ranks 2 and 3 (mask 4'b1100), and a target in ranks 2 or 3 drives mask 4'b0011.
- R7: ODT is driven for a read only if CAS latency plus additive latency is at least 3, and for a write only if write latency plus additive latency is at least 3. Otherwise all ODT lines are 0.
- R8: In paired mode a command steered to rank 1 uses rank 1's own read or write ODT policy.
- R9: `ap_req` is 1 on a hit when the target rank's precharge enable is set, or when `cfg_pre_ivl` is zero. In paired mode, rank 0's precharge enable applies to both paired ranks.
- R10: `ap_bit` is 10 for every accepted command when `cfg_ap_alt` is 0 and 8 when it is 1. It reads 0 while `out_valid` is low.
- R11: After reset, and whenever `out_valid` is low, the outputs are idle: chip selects all ones, ODT 0, `ap_req` 0 and `miss` 0.
- R12: An accepted command's result appears with `out_valid` on the next cycle. `cmd_ready` = !out_valid || out_ready. A result is held stable while `out_ready` is low. The stage empties after a consumed result when no new command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_addr | input | 32 | System address of the command |
| cmd_is_write | input | 1 | 1 for a write, 0 for a read |
| cfg_lo | input | 32 | Per-rank lower bound, rank r in bits [8r+7:8r] |
| cfg_hi | input | 32 | Per-rank upper bound, rank r in bits [8r+7:8r] |
| cfg_rank_en | input | 4 | Per-rank enable |
| cfg_ap_en | input | 4 | Per-rank auto-precharge enable |
| cfg_odt_rd | input | 12 | Per-rank read ODT policy, rank r in bits [3r+2:3r] |
| cfg_odt_wr | input | 12 | Per-rank write ODT policy, rank r in bits [3r+2:3r] |
| cfg_pair_il | input | 1 | Interleave ranks 0 and 1 |
| cfg_ap_alt | input | 1 | Use address bit 8 instead of 10 for auto-precharge |
| cfg_pre_ivl | input | 16 | Global precharge interval; zero forces auto-precharge |
| cfg_cas_lat | input | 4 | CAS latency in clocks |
| cfg_add_lat | input | 4 | Additive latency in clocks |
| cfg_wr_lat | input | 4 | Write latency in clocks |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| cs_n | output | 4 | Active-low chip selects |
| odt | output | 4 | On-die-termination lines per rank |
| ap_req | output | 1 | Auto-precharge requested |
| ap_bit | output | 4 | Address bit carrying auto-precharge |
| miss | output | 1 | No enabled rank claims the address |

## Verification
Every decoded result is due exactly one clock after the edge that accepts its command. `cmd_ready` is combinational and is due in the same cycle that `out_ready` changes. The bench's model advances on each rising edge from the inputs the bench drove half a period earlier. All outputs are compared a short delay after the falling edge, when both the design's registers and the model have settled. Stall sequences with `out_ready` low confirm that a held result stays put for as many cycles as the stall lasts.

// File: rtl/dram_cs_pkg.sv
package dram_cs_pkg;

  typedef enum logic [2:0] {
    ODT_NONE      = 3'd0,
    ODT_TARGET    = 3'd1,
    ODT_NONTARGET = 3'd2,
    ODT_OTHER_MOD = 3'd3,
    ODT_EVERY     = 3'd4
  } odt_pol_e;

  localparam int ODT_POL_W   = 3;
  localparam int AP_POS_NORM = 10;
  localparam int AP_POS_ALT  = 8;
  localparam int ODT_MIN_LAT = 3;

endpackage

// File: rtl/dram_cs_match.sv
module dram_cs_match #(
  parameter int ADDR_W  = 32,
  parameter int BOUND_W = 8,
  parameter int RANKS   = 4
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [RANKS*BOUND_W-1:0] lo_flat,
  input  logic [RANKS*BOUND_W-1:0] hi_flat,
  input  logic [RANKS-1:0]         rank_en,
  input  logic                     pair_il,
  output logic [RANKS-1:0]         hit
);
  localparam int TOP_LSB = ADDR_W - BOUND_W;

  logic [BOUND_W-1:0] page;
  assign page = addr[ADDR_W-1:TOP_LSB];

  // One window comparator per rank; rank 1 is silenced while paired.
  for (genvar g = 0; g < RANKS; g++) begin : g_rank
    logic [BOUND_W-1:0] lo_b;
    logic [BOUND_W-1:0] hi_b;
    logic               allowed;
    assign lo_b = lo_flat[g*BOUND_W +: BOUND_W];
    assign hi_b = hi_flat[g*BOUND_W +: BOUND_W];
    if (g == 1) begin : g_paired
      assign allowed = rank_en[g] & ~pair_il;
    end else begin : g_plain
      assign allowed = rank_en[g];
    end
    assign hit[g] = allowed && (lo_b <= page) && (page <= hi_b);
  end

endmodule

// File: rtl/dram_cs_pick.sv
module dram_cs_pick #(
  parameter int RANKS = 4,
  parameter int RW    = 2
) (
  input  logic [RANKS-1:0] hit,
  input  logic             pair_il,
  input  logic             il_sel,
  output logic [RW-1:0]    tgt,
  output logic             found
);
  // Walk from the highest rank down so the lowest hit is kept last.
  always_comb begin
    tgt   = '0;
    found = 1'b0;
    for (int i = RANKS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        tgt   = RW'(i);
        found = 1'b1;
      end
    end
    if (pair_il && found && (tgt == '0) && il_sel) begin
      tgt = RW'(1);
    end
  end

endmodule

// File: rtl/dram_cs_odt.sv
module dram_cs_odt
  import dram_cs_pkg::*;
#(
  parameter int RANKS = 4,
  parameter int RW    = 2,
  parameter int LAT_W = 4
) (
  input  logic [RW-1:0]              tgt,
  input  logic                       found,
  input  logic                       is_wr,
  input  logic [RANKS*ODT_POL_W-1:0] pol_rd_flat,
  input  logic [RANKS*ODT_POL_W-1:0] pol_wr_flat,
  input  logic [LAT_W-1:0]           cas_lat,
  input  logic [LAT_W-1:0]           add_lat,
  input  logic [LAT_W-1:0]           wr_lat,
  output logic [RANKS-1:0]           odt
);
  localparam int PER_MOD = RANKS / 2;

  logic [ODT_POL_W-1:0] pol;
  logic [LAT_W:0]       lat_sum;
  logic                 lat_ok;
  logic [RANKS-1:0]     self_m;
  logic [RANKS-1:0]     same_mod;
  logic [RANKS-1:0]     raw;

  assign pol     = is_wr ? pol_wr_flat[tgt*ODT_POL_W +: ODT_POL_W]
                         : pol_rd_flat[tgt*ODT_POL_W +: ODT_POL_W];
  assign lat_sum = is_wr ? ({1'b0, wr_lat} + {1'b0, add_lat})
                         : ({1'b0, cas_lat} + {1'b0, add_lat});
  assign lat_ok  = lat_sum >= (LAT_W+1)'(ODT_MIN_LAT);

  always_comb begin
    for (int i = 0; i < RANKS; i++) begin
      self_m[i]   = (RW'(i) == tgt);
      same_mod[i] = ((i / PER_MOD) == (int'(tgt) / PER_MOD));
    end
  end

  always_comb begin
    case (pol)
      ODT_TARGET:    raw = self_m;
      ODT_NONTARGET: raw = ~self_m;
      ODT_OTHER_MOD: raw = ~same_mod;
      ODT_EVERY:     raw = '1;
      default:       raw = '0;
    endcase
  end

  assign odt = (found && lat_ok) ? raw : '0;

endmodule

// File: rtl/dram_cs_decode.sv
module dram_cs_decode
  import dram_cs_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BOUND_W = 8,
  parameter int RANKS   = 4,
  parameter int LAT_W   = 4,
  parameter int IVL_W   = 16,
  parameter int IL_BIT  = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [ADDR_W-1:0]          cmd_addr,
  input  logic                       cmd_is_write,
  input  logic [RANKS*BOUND_W-1:0]   cfg_lo,
  input  logic [RANKS*BOUND_W-1:0]   cfg_hi,
  input  logic [RANKS-1:0]           cfg_rank_en,
  input  logic [RANKS-1:0]           cfg_ap_en,
  input  logic [RANKS*ODT_POL_W-1:0] cfg_odt_rd,
  input  logic [RANKS*ODT_POL_W-1:0] cfg_odt_wr,
  input  logic                       cfg_pair_il,
  input  logic                       cfg_ap_alt,
  input  logic [IVL_W-1:0]           cfg_pre_ivl,
  input  logic [LAT_W-1:0]           cfg_cas_lat,
  input  logic [LAT_W-1:0]           cfg_add_lat,
  input  logic [LAT_W-1:0]           cfg_wr_lat,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [RANKS-1:0]           cs_n,
  output logic [RANKS-1:0]           odt,
  output logic                       ap_req,
  output logic [3:0]                 ap_bit,
  output logic                       miss
);
  localparam int RW = (RANKS > 1) ? $clog2(RANKS) : 1;

  logic [RANKS-1:0] hit;
  logic [RW-1:0]    tgt;
  logic             found;
  logic [RANKS-1:0] odt_nx;
  logic             ap_src;
  logic             ap_nx;
  logic             accept;

  dram_cs_match #(.ADDR_W(ADDR_W), .BOUND_W(BOUND_W), .RANKS(RANKS)) match_i (
    .addr(cmd_addr), .lo_flat(cfg_lo), .hi_flat(cfg_hi),
    .rank_en(cfg_rank_en), .pair_il(cfg_pair_il), .hit(hit)
  );

  dram_cs_pick #(.RANKS(RANKS), .RW(RW)) pick_i (
    .hit(hit), .pair_il(cfg_pair_il), .il_sel(cmd_addr[IL_BIT]),
    .tgt(tgt), .found(found)
  );

  dram_cs_odt #(.RANKS(RANKS), .RW(RW), .LAT_W(LAT_W)) odt_i (
    .tgt(tgt), .found(found), .is_wr(cmd_is_write),
    .pol_rd_flat(cfg_odt_rd), .pol_wr_flat(cfg_odt_wr),
    .cas_lat(cfg_cas_lat), .add_lat(cfg_add_lat), .wr_lat(cfg_wr_lat),
    .odt(odt_nx)
  );

  // Paired ranks share rank 0's precharge setting.
  assign ap_src    = (cfg_pair_il && (tgt <= RW'(1))) ? cfg_ap_en[0] : cfg_ap_en[tgt];
  assign ap_nx     = found && (ap_src || (cfg_pre_ivl == '0));
  assign cmd_ready = !out_valid || out_ready;
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cs_n      <= '1;
      odt       <= '0;
      ap_req    <= 1'b0;
      ap_bit    <= '0;
      miss      <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      cs_n      <= found ? ~(RANKS'(1) << tgt) : '1;
      odt       <= odt_nx;
      ap_req    <= ap_nx;
      ap_bit    <= cfg_ap_alt ? 4'(AP_POS_ALT) : 4'(AP_POS_NORM);
      miss      <= !found;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      cs_n      <= '1;
      odt       <= '0;
      ap_req    <= 1'b0;
      ap_bit    <= '0;
      miss      <= 1'b0;
    end
  end

  AST_CS_ONE_RANK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(~cs_n)); // R3

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (cs_n == '1 && odt == '0 && !ap_req)); // R3

  AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (cs_n == '1 && odt == '0 && !ap_req && !miss)); // R11

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(cs_n) && $stable(odt)
      && $stable(ap_req) && $stable(ap_bit) && $stable(miss))); // R12

  AST_AP_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ap_bit == 4'(AP_POS_NORM) || ap_bit == 4'(AP_POS_ALT))); // R10

  AST_TAKE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> out_valid); // R12

endmodule

// File: tb/dram_cs_decode_tb_top.sv
module dram_cs_decode_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic        cmd_is_write = 1'b0;
  logic [7:0]  lo_b [4];
  logic [7:0]  hi_b [4];
  logic [2:0]  prd [4];
  logic [2:0]  pwr [4];
  logic [31:0] cfg_lo, cfg_hi;
  logic [11:0] cfg_odt_rd, cfg_odt_wr;
  logic [3:0]  cfg_rank_en = 4'hF;
  logic [3:0]  cfg_ap_en = 4'h0;
  logic        cfg_pair_il = 1'b0;
  logic        cfg_ap_alt = 1'b0;
  logic [15:0] cfg_pre_ivl = 16'h0100;
  logic [3:0]  cas = 4'd3, al = 4'd0, wl = 4'd3;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  cs_n, odt;
  logic        ap_req, miss;
  logic [3:0]  ap_bit;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string tag = "R11";

  always #5 clk = ~clk;

  always_comb begin
    for (int r = 0; r < 4; r++) begin
      cfg_lo[r*8 +: 8]     = lo_b[r];
      cfg_hi[r*8 +: 8]     = hi_b[r];
      cfg_odt_rd[r*3 +: 3] = prd[r];
      cfg_odt_wr[r*3 +: 3] = pwr[r];
    end
  end

  dram_cs_decode dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_is_write(cmd_is_write),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_rank_en(cfg_rank_en), .cfg_ap_en(cfg_ap_en),
    .cfg_odt_rd(cfg_odt_rd), .cfg_odt_wr(cfg_odt_wr), .cfg_pair_il(cfg_pair_il),
    .cfg_ap_alt(cfg_ap_alt), .cfg_pre_ivl(cfg_pre_ivl), .cfg_cas_lat(cas),
    .cfg_add_lat(al), .cfg_wr_lat(wl), .out_valid(out_valid), .out_ready(out_ready),
    .cs_n(cs_n), .odt(odt), .ap_req(ap_req), .ap_bit(ap_bit), .miss(miss)
  );

  // Reference model: expected output stage, advanced on each rising edge.
  logic       m_valid;
  logic [3:0] e_cs, e_odt, e_bit;
  logic       e_ap, e_miss;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; e_cs = 4'hF; e_odt = 0; e_ap = 0; e_bit = 0; e_miss = 0;
    end else if (cmd_valid && (!m_valid || out_ready)) begin
      int t; int sum; int pol; int pg;
      t = -1; pg = int'(cmd_addr[31:24]);
      if (cfg_pair_il && cfg_rank_en[0] && lo_b[0] <= pg && pg <= hi_b[0])
        t = cmd_addr[6] ? 1 : 0;
      for (int r = 0; r < 4; r++)
        if (t < 0 && !(cfg_pair_il && r < 2) && cfg_rank_en[r] && lo_b[r] <= pg && pg <= hi_b[r])
          t = r;
      m_valid = 1;
      e_bit = cfg_ap_alt ? 4'd8 : 4'd10;
      if (t < 0) begin
        e_cs = 4'hF; e_odt = 0; e_ap = 0; e_miss = 1;
      end else begin
        e_miss = 0;
        e_cs = ~(4'b1 << t);
        pol = cmd_is_write ? int'(pwr[t]) : int'(prd[t]);
        sum = cmd_is_write ? int'(wl) + int'(al) : int'(cas) + int'(al);
        e_odt = 0;
        if (sum >= 3) begin
          case (pol)
            1: e_odt = 4'b1 << t;
            2: e_odt = ~(4'b1 << t);
            3: e_odt = (t < 2) ? 4'b1100 : 4'b0011;
            4: e_odt = 4'hF;
            default: e_odt = 0;
          endcase
        end
        e_ap = ((cfg_pair_il && t < 2) ? cfg_ap_en[0] : cfg_ap_en[t]) || (cfg_pre_ivl == 0);
      end
    end else if (out_ready) begin
      m_valid = 0; e_cs = 4'hF; e_odt = 0; e_ap = 0; e_bit = 0; e_miss = 0;
    end
  end

  task automatic chk(string fld, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, fld, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (cycles > 0) begin
      chk("out_valid", int'(out_valid), int'(m_valid));
      chk("cmd_ready", int'(cmd_ready), int'(!m_valid || out_ready));
      chk("cs_n", int'(cs_n), int'(e_cs));
      chk("odt", int'(odt), int'(e_odt));
      chk("ap_req", int'(ap_req), int'(e_ap));
      chk("ap_bit", int'(ap_bit), int'(e_bit));
      chk("miss", int'(miss), int'(e_miss));
    end
    cycles++;
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic issue(logic [31:0] a, logic wr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_is_write = wr;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
    end
  endtask

  task automatic base_cfg();
    lo_b[0] = 8'h00; hi_b[0] = 8'h0F; lo_b[1] = 8'h10; hi_b[1] = 8'h1F;
    lo_b[2] = 8'h20; hi_b[2] = 8'h7F; lo_b[3] = 8'h80; hi_b[3] = 8'hFF;
    for (int r = 0; r < 4; r++) begin prd[r] = 3'd1; pwr[r] = 3'd1; end
    cfg_rank_en = 4'hF; cfg_pair_il = 0; cfg_ap_en = 0; cfg_pre_ivl = 16'h0100;
    cfg_ap_alt = 0; cas = 3; al = 0; wl = 3;
  endtask

  initial begin
    base_cfg();
    idle(3);                         // R11: reset state observed
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    tag = "R1";                      // inclusive window edges
    issue(32'h0000_0000, 0); issue(32'h0FFF_FFFF, 1); issue(32'h1000_0000, 0);
    issue(32'h1F00_0000, 1); issue(32'h2000_0000, 0); issue(32'h7FFF_0000, 1);
    issue(32'h8000_0000, 0); issue(32'hFFFF_FFFF, 1);
    issue(32'h1F00_0000, 0); lo_b[1] = 8'h30; hi_b[1] = 8'h20; // inverted window
    issue(32'h2500_0000, 0); idle(2);

    tag = "R2"; base_cfg(); cfg_rank_en = 4'b1011;
    issue(32'h3000_0000, 0); issue(32'h0500_0000, 1); idle(2);

    tag = "R3"; base_cfg(); lo_b[3] = 8'h00;
    issue(32'h0500_0000, 0); issue(32'h1500_0000, 1); issue(32'h5000_0000, 0);
    cfg_rank_en = 4'b0000; issue(32'h9000_0000, 1); idle(2);

    tag = "R4"; base_cfg(); cfg_pair_il = 1; hi_b[0] = 8'h3F; lo_b[2] = 8'h40;
    lo_b[1] = 8'h00; hi_b[1] = 8'hFF;
    issue(32'h1000_0000, 0); issue(32'h1000_0040, 0); issue(32'h3F00_0040, 1);
    issue(32'h5000_0040, 0); cfg_rank_en = 4'b1110; issue(32'h1000_0040, 0); idle(2);

    tag = "R5"; base_cfg();
    for (int c = 0; c < 8; c++) begin
      prd[2] = 3'(c); pwr[2] = 3'(7 - c);
      issue(32'h4000_0000, 0); issue(32'h4000_0000, 1);
    end
    idle(2);

    tag = "R6"; base_cfg();
    for (int r = 0; r < 4; r++) begin prd[r] = 3'd3; pwr[r] = 3'd3; end
    issue(32'h0100_0000, 0); issue(32'h1100_0000, 1);
    issue(32'h2100_0000, 0); issue(32'hA100_0000, 1); idle(2);

    tag = "R7"; base_cfg(); cas = 2; al = 0; wl = 1;
    issue(32'h4000_0000, 0); issue(32'h4000_0000, 1);
    al = 1; issue(32'h4000_0000, 0); issue(32'h4000_0000, 1);
    al = 2; issue(32'h4000_0000, 1); idle(2);

    tag = "R8"; base_cfg(); cfg_pair_il = 1; prd[1] = 3'd4; pwr[1] = 3'd2; prd[0] = 3'd0;
    issue(32'h0200_0040, 0); issue(32'h0200_0040, 1); issue(32'h0200_0000, 0); idle(2);

    tag = "R9"; base_cfg(); cfg_ap_en = 4'b0100;
    issue(32'h4000_0000, 0); issue(32'h9000_0000, 0);
    cfg_pre_ivl = 0; issue(32'h9000_0000, 1); cfg_pre_ivl = 16'h0100;
    cfg_pair_il = 1; cfg_ap_en = 4'b0001; issue(32'h0000_0040, 0);
    cfg_ap_en = 4'b0010; issue(32'h0000_0040, 0); idle(2);

    tag = "R10"; base_cfg(); cfg_ap_alt = 1;
    issue(32'h4000_0000, 0); issue(32'h9000_0000, 1); cfg_ap_alt = 0;
    issue(32'h4000_0000, 0); idle(2);

    tag = "R12"; base_cfg();
    issue(32'h0000_0000, 0); out_ready = 0;
    issue(32'h4000_0000, 1); issue(32'h9000_0000, 0); issue(32'h1000_0000, 1);
    @(negedge clk); out_ready = 1; idle(3);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      cmd_valid = 1'($urandom_range(0, 1)); out_ready = ($urandom_range(0, 3) != 0);
      cmd_addr = $urandom; cmd_is_write = 1'($urandom_range(0, 1));
      if (i % 8 == 0) begin
        for (int r = 0; r < 4; r++) begin
          lo_b[r] = 8'($urandom); hi_b[r] = 8'($urandom);
          prd[r] = 3'($urandom); pwr[r] = 3'($urandom);
        end
        cfg_rank_en = 4'($urandom); cfg_ap_en = 4'($urandom);
        cfg_pair_il = 1'($urandom); cfg_ap_alt = 1'($urandom);
        cfg_pre_ivl = 16'($urandom_range(0, 1));
        cas = 4'($urandom_range(0, 3)); al = 4'($urandom_range(0, 2));
        wl = 4'($urandom_range(0, 3));
      end
    end
    out_ready = 1; idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule